// File: doc/BRIEF.md
# SPI Slave-Port FPGA Configuration Loader

This block acts as the master side of an FPGA configuration link. It loads a bitstream into the configuration memory of a target FPGA that listens on its slave SPI port. On a start pulse it checks the requested settings. It then pulls the target's reset and chip-select low together and holds them. It releases reset and confirms that the target's done flag has gone low. With chip-select still asserted it waits out the target's internal housekeeping time, and then releases chip-select.

After that it streams the bitstream bytes from a valid/ready byte source under a fresh chip-select, most significant bit first, in clock phase 0. When the byte marked last has been sent, it confirms that the target raised its done flag. It then clocks a short run of zero bytes to wake the loaded design. Busy, done and error outputs report the outcome, and a code tells the error causes apart.

All delays are counted in system clock cycles and derived from a clock-frequency parameter. The SPI clock half-period is a run-time setting that is checked against the target's legal clock range.

Top module: `fpga_cfg_loader`

## Requirements
- R1: The half-period setting `cfg_half` (system cycles per SCLK level) must give an SCLK frequency CLK_HZ/(2·cfg_half) between 1 MHz and 25 MHz inclusive. Otherwise the start ends at once with error code 1 and the target pins are never driven.
- R2: A start with `cfg_cpha` high ends at once with error code 2, and the target pins are never driven.
- R3: A start with `cfg_partial` high ends at once with error code 3. The target pins are never driven and no bitstream byte is accepted. The checks run in the order R3, then R2, then R1.
- R4: An accepted start drives `tgt_rst_n` and `tgt_cs_n` low on the same edge. Reset stays low for at least HOLD_NS worth of cycles and is then released while chip-select is still low. Reset is never low while chip-select is high.
- R5: If the synchronized done flag reads high after reset is released, the load ends with error code 4. Chip-select goes high, reset stays released and no byte is accepted.
- R6: Chip-select stays low for at least HOLD_NS plus HOUSEKEEP_US worth of cycles from the start, carrying no SCLK activity. It then goes high before the bitstream is sent under a new chip-select assertion. `s_ready` is only high while chip-select is low during streaming.
- R7: Bitstream bytes reach the target unmodified, MSB first, in SPI mode 0. SCLK idles low whenever chip-select is high, and MOSI is stable while SCLK is high. Gaps in `s_valid` do not corrupt the stream.
- R8: If the done flag is low once the last byte has been sent, the load ends with error code 5 and no activation bytes are sent.
- R9: On a good load, ACT_BYTES (7) bytes of 0x00 are sent under a third chip-select assertion, and then `done` rises.
- R10: `busy` is high from the cycle after an accepted start until the outcome. `done` and `err` are never high together or while busy, and they hold until the next start clears them. `err_code` is 0 when there is no error.
- R11: A start pulse while busy is ignored and does not change the ongoing load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (pulse) |
| cfg_half | input | DIV_W | SCLK half-period in system cycles |
| cfg_cpha | input | 1 | Requested clock phase (only 0 is legal) |
| cfg_partial | input | 1 | Partial-load request (refused) |
| s_valid | input | 1 | Bitstream byte valid |
| s_data | input | 8 | Bitstream byte |
| s_last | input | 1 | Marks the final bitstream byte |
| s_ready | output | 1 | Loader accepts the byte this cycle |
| tgt_done | input | 1 | Target's done flag (asynchronous) |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| tgt_sclk | output | 1 | SPI clock |
| tgt_mosi | output | 1 | SPI data to target |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load succeeded |
| err | output | 1 | Last start failed |
| err_code | output | 3 | 0 none, 1 rate, 2 phase, 3 partial, 4 reset-check, 5 transfer-check |

## Verification
The bench builds the loader with CLK_HZ at 100 MHz, HOLD_NS at 1000 and HOUSEKEEP_US shortened to 10. The housekeeping wait then lasts 1000 cycles, so many complete loads fit in one run. At 100 MHz both clock-range limits fall on integer half-periods: 2 gives exactly 25 MHz and 50 gives exactly 1 MHz. This lets the bench run good loads at both edges and refuse 0, 1 and 51 just outside them. A behavioural target model records every chip-select window and the bytes inside it, and drives the done flag normal, stuck high or never high.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_RATE    = 3'd1,
    ERR_PHASE   = 3'd2,
    ERR_UNSUP   = 3'd3,
    ERR_RSTFAIL = 3'd4,
    ERR_XFER    = 3'd5
  } err_code_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RESET_HOLD,
    S_CHECK_LOW,
    S_HOUSEKEEP,
    S_GAP,
    S_STREAM,
    S_CHECK_HIGH,
    S_ACTIVATE
  } load_state_e;

endpackage

// File: rtl/cfg_done_sync.sv
module cfg_done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half,
  input  logic             load,
  input  logic [7:0]       byte_in,
  output logic             busy,
  output logic             sclk,
  output logic             mosi
);
  logic [DIV_W-1:0] tmr;
  logic [6:0]       rest;
  logic [2:0]       bitn;
  logic             high_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      sclk       <= 1'b0;
      mosi       <= 1'b0;
      rest       <= '0;
      bitn       <= '0;
      tmr        <= '0;
      high_phase <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        busy       <= 1'b1;
        mosi       <= byte_in[7];
        rest       <= byte_in[6:0];
        bitn       <= '0;
        high_phase <= 1'b0;
        tmr        <= half - 1'b1;
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else if (!high_phase) begin
      sclk       <= 1'b1;
      high_phase <= 1'b1;
      tmr        <= half - 1'b1;
    end else begin
      sclk       <= 1'b0;
      high_phase <= 1'b0;
      if (bitn == 3'd7) begin
        busy <= 1'b0;
      end else begin
        mosi <= rest[6];
        rest <= {rest[5:0], 1'b0};
        bitn <= bitn + 1'b1;
        tmr  <= half - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
  import cfg_loader_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int HOLD_CYC  = 100,
  parameter int HK_CYC    = 120000,
  parameter int SETTLE    = 4,
  parameter int GAP_CYC   = 4,
  parameter int ACT_BYTES = 7,
  parameter int MIN_HALF  = 2,
  parameter int MAX_HALF  = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             cfg_cpha,
  input  logic             cfg_partial,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  input  logic             done_sync,
  input  logic             tx_busy,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  output logic [DIV_W-1:0] half_q,
  output logic             tgt_rst_n,
  output logic             tgt_cs_n,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);
  localparam int MAX_CYC = (HK_CYC > HOLD_CYC) ? HK_CYC : HOLD_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam int ACT_W   = $clog2(ACT_BYTES + 1);

  load_state_e     state;
  logic [TMR_W-1:0] timer;
  logic [ACT_W-1:0] act_cnt;
  logic             last_seen;
  logic             rate_ok, take, act_load, tmr_zero;

  assign rate_ok  = (32'(cfg_half) >= 32'(MIN_HALF)) && (32'(cfg_half) <= 32'(MAX_HALF));
  assign s_ready  = (state == S_STREAM) && !tx_busy && !last_seen;
  assign take     = s_ready && s_valid;
  assign act_load = (state == S_ACTIVATE) && !tx_busy && (act_cnt != ACT_W'(ACT_BYTES));
  assign tx_load  = take || act_load;
  assign tx_byte  = act_load ? 8'h00 : s_data;
  assign tmr_zero = (timer == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      timer     <= '0;
      act_cnt   <= '0;
      last_seen <= 1'b0;
      half_q    <= '0;
      tgt_rst_n <= 1'b1;
      tgt_cs_n  <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          err      <= 1'b0;
          err_code <= ERR_NONE;
          if (cfg_partial) begin
            err <= 1'b1; err_code <= ERR_UNSUP;
          end else if (cfg_cpha) begin
            err <= 1'b1; err_code <= ERR_PHASE;
          end else if (!rate_ok) begin
            err <= 1'b1; err_code <= ERR_RATE;
          end else begin
            busy      <= 1'b1;
            half_q    <= cfg_half;
            tgt_rst_n <= 1'b0;
            tgt_cs_n  <= 1'b0;
            timer     <= TMR_W'(HOLD_CYC - 1);
            state     <= S_RESET_HOLD;
          end
        end
        S_RESET_HOLD: if (tmr_zero) begin
          tgt_rst_n <= 1'b1;
          timer     <= TMR_W'(SETTLE - 1);
          state     <= S_CHECK_LOW;
        end else timer <= timer - 1'b1;
        S_CHECK_LOW: if (tmr_zero) begin
          if (done_sync) begin
            tgt_cs_n <= 1'b1;
            busy     <= 1'b0;
            err      <= 1'b1;
            err_code <= ERR_RSTFAIL;
            state    <= S_IDLE;
          end else begin
            timer <= TMR_W'(HK_CYC - 1);
            state <= S_HOUSEKEEP;
          end
        end else timer <= timer - 1'b1;
        S_HOUSEKEEP: if (tmr_zero) begin
          tgt_cs_n <= 1'b1;
          timer    <= TMR_W'(GAP_CYC - 1);
          state    <= S_GAP;
        end else timer <= timer - 1'b1;
        S_GAP: if (tmr_zero) begin
          tgt_cs_n  <= 1'b0;
          last_seen <= 1'b0;
          state     <= S_STREAM;
        end else timer <= timer - 1'b1;
        S_STREAM: if (take) begin
          if (s_last) last_seen <= 1'b1;
        end else if (last_seen && !tx_busy) begin
          tgt_cs_n <= 1'b1;
          timer    <= TMR_W'(SETTLE - 1);
          state    <= S_CHECK_HIGH;
        end
        S_CHECK_HIGH: if (tmr_zero) begin
          if (!done_sync) begin
            busy     <= 1'b0;
            err      <= 1'b1;
            err_code <= ERR_XFER;
            state    <= S_IDLE;
          end else begin
            tgt_cs_n <= 1'b0;
            act_cnt  <= '0;
            state    <= S_ACTIVATE;
          end
        end else timer <= timer - 1'b1;
        S_ACTIVATE: if (act_load) begin
          act_cnt <= act_cnt + 1'b1;
        end else if (!tx_busy) begin
          tgt_cs_n <= 1'b1;
          busy     <= 1'b0;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SCLK_MIN_HZ  = 1_000_000,
  parameter int SCLK_MAX_HZ  = 25_000_000,
  parameter int HOLD_NS      = 1000,
  parameter int HOUSEKEEP_US = 1200,
  parameter int ACT_BYTES    = 7,
  parameter int SYNC_STAGES  = 2,
  parameter int DIV_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             cfg_cpha,
  input  logic             cfg_partial,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  input  logic             tgt_done,
  output logic             tgt_rst_n,
  output logic             tgt_cs_n,
  output logic             tgt_sclk,
  output logic             tgt_mosi,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);
  localparam int HOLD_CYC = int'((64'(HOLD_NS) * 64'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int HK_CYC   = HOUSEKEEP_US * (CLK_HZ / 1_000_000);
  localparam int MIN_HALF = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int MAX_HALF = CLK_HZ / (2 * SCLK_MIN_HZ);
  localparam int SETTLE   = SYNC_STAGES + 2;

  logic             done_sync, tx_busy, tx_load;
  logic [7:0]       tx_byte;
  logic [DIV_W-1:0] half_q;

  cfg_done_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(tgt_done), .sync_out(done_sync)
  );

  cfg_load_fsm #(
    .DIV_W(DIV_W), .HOLD_CYC(HOLD_CYC), .HK_CYC(HK_CYC), .SETTLE(SETTLE),
    .GAP_CYC(4), .ACT_BYTES(ACT_BYTES), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .cfg_half(cfg_half),
    .cfg_cpha(cfg_cpha), .cfg_partial(cfg_partial),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .done_sync(done_sync), .tx_busy(tx_busy), .tx_load(tx_load),
    .tx_byte(tx_byte), .half_q(half_q),
    .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  cfg_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .half(half_q), .load(tx_load), .byte_in(tx_byte),
    .busy(tx_busy), .sclk(tgt_sclk), .mosi(tgt_mosi)
  );
endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [DIV_W-1:0] cfg_half,
  input logic             cfg_cpha,
  input logic             cfg_partial,
  input logic             s_valid,
  input logic [7:0]       s_data,
  input logic             s_last,
  input logic             s_ready,
  input logic             tgt_done,
  input logic             tgt_rst_n,
  input logic             tgt_cs_n,
  input logic             tgt_sclk,
  input logic             tgt_mosi,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [2:0]       err_code
);
  assert_rst_under_cs_R4: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n |-> !tgt_cs_n);

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    tgt_cs_n |-> !tgt_sclk);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tgt_sclk && $past(tgt_sclk)) |-> $stable(tgt_mosi));

  assert_status_excl_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(done || err));

  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  assert_code_valid_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 3'd0));

  assert_cfg_untouched_R3: assert property (@(posedge clk) disable iff (rst)
    (err && (err_code == 3'd1 || err_code == 3'd2 || err_code == 3'd3))
      |-> (tgt_cs_n && tgt_rst_n));

  assert_ready_under_cs_R6: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (!tgt_cs_n && tgt_rst_n && busy));

  assert_fail_releases_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (tgt_cs_n && tgt_rst_n));
endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/test_fpga_cfg_loader.sv
module test_fpga_cfg_loader;
  localparam int HOLD_EXP = 100;   // 1000 ns at 100 MHz
  localparam int HK_EXP   = 1000;  // 10 us at 100 MHz

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] cfg_half = 8'd2;
  logic cfg_cpha = 1'b0, cfg_partial = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, tdone = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, tgt_rst_n, tgt_cs_n, tgt_sclk, tgt_mosi, busy, done, err;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  fpga_cfg_loader #(.CLK_HZ(100_000_000), .HOLD_NS(1000), .HOUSEKEEP_US(10),
                    .ACT_BYTES(7)) i_fpga_cfg_loader (
    .clk(clk), .rst(rst), .start(start), .cfg_half(cfg_half),
    .cfg_cpha(cfg_cpha), .cfg_partial(cfg_partial), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .tgt_done(tdone),
    .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n), .tgt_sclk(tgt_sclk),
    .tgt_mosi(tgt_mosi), .busy(busy), .done(done), .err(err), .err_code(err_code));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model: chip-select windows and the bytes inside them
  int seg = -1, bitc = 0, rst_low = 0, exp_n = 0, dmode = 0;
  int seg_len [0:7];
  int seg_nb  [0:7];
  int rxq [$];
  logic [7:0] shreg = 8'h00;
  logic cs_prev = 1'b1, sclk_prev = 1'b0, rst_prev = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      chk(tgt_rst_n || !tgt_cs_n, "R4 reset low only under chip-select", int'(tgt_cs_n), 0);
      chk(!tgt_cs_n || !tgt_sclk, "R7 sclk idles low", int'(tgt_sclk), 0);
    end
    if (!tgt_cs_n && cs_prev && seg < 7) begin
      seg++; seg_len[seg] = 0; seg_nb[seg] = 0; bitc = 0;
    end
    if (!tgt_cs_n && seg >= 0) seg_len[seg]++;
    if (tgt_sclk && !sclk_prev && !tgt_cs_n && seg >= 0) begin
      shreg = {shreg[6:0], tgt_mosi};
      bitc++;
      if (bitc == 8) begin
        rxq.push_back(seg * 256 + int'(shreg));
        seg_nb[seg]++;
        bitc = 0;
      end
    end
    if (!tgt_rst_n) rst_low++;
    if (tgt_rst_n && !rst_prev) begin
      chk(!tgt_cs_n, "R4 cs still low at reset release", int'(tgt_cs_n), 0);
      chk(rst_low >= HOLD_EXP, "R4 reset hold length", rst_low, HOLD_EXP);
      rst_low = 0;
    end
    if (dmode == 1) tdone = 1'b1;
    else if (!tgt_rst_n) tdone = 1'b0;
    else if (dmode == 0 && seg == 1 && seg_nb[1] >= exp_n) tdone = 1'b1;
    cs_prev = tgt_cs_n; sclk_prev = tgt_sclk; rst_prev = tgt_rst_n;
  end

  // byte source
  logic [7:0] feed [0:15];
  int idx = 0, feed_n = 0, cyc = 0;
  bit feed_on = 0, took = 0, gap_mode = 0;

  always @(negedge clk) begin
    cyc++;
    if (feed_on) begin
      if (took) begin idx++; took = 0; end
      if (idx < feed_n) begin
        s_valid = !(gap_mode && (cyc % 3 == 0));
        s_data  = feed[idx];
        s_last  = (idx == feed_n - 1);
        took    = s_valid && s_ready;
      end else s_valid = 1'b0;
    end
  end

  task automatic run_load(input int half, input bit cpha, input bit part, input int n,
                          input int dm, input bit gap, input int exp_code, input bit poke);
    int t;
    for (int i = 0; i < 16; i++) feed[i] = 8'((i * 37 + half * 11 + 8'h5A) & 255);
    feed[0] = 8'h81;
    rxq.delete();
    for (int i = 0; i < 8; i++) begin seg_len[i] = 0; seg_nb[i] = 0; end
    seg = -1; idx = 0; took = 0; feed_n = n; exp_n = n; dmode = dm; gap_mode = gap;
    @(negedge clk);
    cfg_half = 8'(half); cfg_cpha = cpha; cfg_partial = part; start = 1'b1; feed_on = 1;
    @(negedge clk);
    start = 1'b0;
    if (exp_code >= 1 && exp_code <= 3) begin
      chk(err && !busy && !done, "R1/R2/R3 immediate refusal", int'(err), 1);
      chk(int'(err_code) == exp_code, "R1 R2 R3 refusal code", int'(err_code), exp_code);
    end else begin
      chk(busy && !done && !err, "R10 busy after accepted start", int'(busy), 1);
    end
    t = 0;
    while (!(done || err) && t < 60000) begin
      if (poke && t == 400) begin cfg_partial = 1'b1; start = 1'b1; end
      else begin start = 1'b0; cfg_partial = part; end
      @(negedge clk);
      t++;
    end
    start = 1'b0; cfg_partial = 1'b0;
    repeat (3) @(negedge clk);
    feed_on = 0; s_valid = 1'b0;
    chk(int'(err_code) == exp_code, "R10 outcome code", int'(err_code), exp_code);
    chk(tgt_cs_n && tgt_rst_n, "R10 target released at end", int'({tgt_cs_n, tgt_rst_n}), 3);
    if (exp_code == 0) begin
      chk(done && !err && !busy, "R10 done reported", int'(done), 1);
      chk(seg == 2, "R6 three chip-select windows", seg, 2);
      chk(seg_nb[0] == 0, "R6 no clocks during housekeeping", seg_nb[0], 0);
      chk(seg_len[0] >= HOLD_EXP + HK_EXP, "R6 housekeeping length", seg_len[0], HOLD_EXP + HK_EXP);
      chk(seg_nb[1] == n, "R7 byte count", seg_nb[1], n);
      chk(seg_nb[2] == 7, "R9 activation byte count", seg_nb[2], 7);
      for (int i = 0; i < rxq.size(); i++) begin
        if (rxq[i] / 256 == 1 && i - seg_nb[0] < 16)
          chk(rxq[i] % 256 == int'(feed[i - seg_nb[0]]), "R7 byte value", rxq[i] % 256,
              int'(feed[i - seg_nb[0]]));
        if (rxq[i] / 256 == 2)
          chk(rxq[i] % 256 == 0, "R9 activation byte zero", rxq[i] % 256, 0);
      end
    end else if (exp_code <= 3) begin
      chk(seg == -1, "R3 target untouched", seg, -1);
      chk(idx == 0, "R3 no byte accepted", idx, 0);
    end else if (exp_code == 4) begin
      chk(seg == 0, "R5 only reset window", seg, 0);
      chk(idx == 0, "R5 no byte accepted", idx, 0);
    end else begin
      chk(seg == 1, "R8 no activation window", seg, 1);
      chk(seg_nb[1] == n, "R8 stream was sent", seg_nb[1], n);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tgt_cs_n && tgt_rst_n && !tgt_sclk, "R10 reset pins idle", int'({tgt_cs_n, tgt_rst_n}), 3);
    chk(!busy && !done && !err && !s_ready, "R10 reset status clear", int'({busy, done, err}), 0);
    chk(err_code == 3'd0, "R10 reset code", int'(err_code), 0);

    run_load(2, 0, 0, 6, 0, 0, 0, 0);   // R1 upper rate edge, R7, R9
    repeat (30) @(negedge clk);
    chk(done && !err, "R10 done sticky", int'(done), 1);
    run_load(50, 0, 0, 2, 0, 1, 0, 0);  // R1 lower rate edge, R7 with gaps
    run_load(3, 0, 0, 9, 0, 1, 0, 1);   // R11 start while busy
    run_load(1, 0, 0, 3, 0, 0, 1, 0);   // R1 too fast
    run_load(51, 0, 0, 3, 0, 0, 1, 0);  // R1 too slow
    run_load(0, 0, 0, 3, 0, 0, 1, 0);   // R1 zero
    run_load(4, 1, 0, 3, 0, 0, 2, 0);   // R2
    run_load(4, 0, 1, 3, 0, 0, 3, 0);   // R3
    run_load(1, 1, 1, 3, 0, 0, 3, 0);   // R3 priority
    run_load(4, 0, 0, 3, 1, 0, 4, 0);   // R5 done stuck high
    run_load(4, 0, 0, 4, 2, 0, 5, 0);   // R8 done never high
    run_load(4, 0, 0, 5, 0, 0, 0, 0);   // recovery after failures
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule